// File: doc/BRIEF.md
# Snooping Cache Miss Controller

This block runs one processor's private cache on a shared snooping bus. The cache is direct mapped and holds each line in one of four states: invalid, shared, exclusive or modified. On a miss it puts a read request for the line on the bus. Once the bus grants the request, it asks main memory for the line. If a peer cache answers first, the memory request is cancelled in that same cycle and the peer's copy is used. A line that arrives from memory has no other holder, so it is held exclusive, and a later store to it changes it to modified with no bus traffic. A line that arrives from a peer is held shared. A store to a shared line first has to win an invalidate on the bus.

At the same time the block watches the requests that other caches place on the bus. A snooped read that hits supplies the line, and the line drops to shared. If the line was modified, it is also written back to memory. A snooped invalidate that hits drops the line to invalid. Together these rules mean that no two caches ever both hold a writable copy of the same line.

The main state machine has six states. IDLE looks up the request. RESP returns the result for one cycle. EVICT writes back a dirty victim. BUSRD waits for the bus grant of a read. WAITF waits for the line to arrive. UPG waits for the grant of an invalidate. The transitions are as follows:
- IDLE goes to RESP on a read hit, or on a store hit to an exclusive or modified line.
- IDLE goes to UPG on a store hit to a shared line.
- IDLE goes to EVICT on a miss whose victim is modified, and to BUSRD on a miss whose victim is clean.
- EVICT goes to BUSRD.
- BUSRD goes to WAITF on grant.
- WAITF goes to IDLE on the fill, and the request is looked up again.
- UPG goes to RESP on grant, or to IDLE if the line was invalidated while waiting.
- RESP goes to IDLE.

Top module: `scm_ctrl`

## Requirements
- R1: After reset every line is invalid. No response, bus request, memory read or memory write is asserted, and a snooped read is not supplied.
- R2: A read hit asserts cpu_done for exactly one cycle, in the cycle after the request is first seen, with the addressed word on cpu_rdata and no bus traffic. Address bits [1:0] select the word, [5:2] the line and [11:6] the tag. Word w sits at line bits [32w+31:32w].
- R3: A miss holds bus_req with bus_inv low and a stable line address (word address shifted right by 2) until bus_gnt. After the grant it holds mem_rd with the same line address until the line arrives.
- R4: A fill from memory (mem_ack) leaves the line exclusive. A later store to it completes without any bus request.
- R5: When peer_valid arrives while mem_rd is high, mem_cancel is asserted in that cycle and the peer's line is used. This holds even if mem_ack arrives in the same cycle. The line is held shared.
- R6: A store to a shared line requests the bus with bus_inv high and becomes modified on grant. If the line is invalidated by a snoop before the grant, the request is dropped and the store is served as a miss.
- R7: A snooped read (snp_inv low) that hits a valid line asserts snp_supply with the line on snp_line in the same cycle. A modified line is also written to memory in that cycle, and the line becomes shared.
- R8: A snooped invalidate (snp_inv high) that hits makes the line invalid, so the next access to it misses.
- R9: A snoop whose tag does not match the stored line supplies nothing and leaves the line unchanged.
- R10: A miss whose victim is modified writes the victim line and its line address to memory before the bus read is issued.
- R11: A processor request to the same line index as a snoop in the same cycle is held back one cycle, so it acts on the state the snoop leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load data, valid with cpu_done |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_inv | output | 1 | Request kind: 1 = invalidate, 0 = read |
| bus_addr | output | AW-2 | Line address of the request |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| peer_valid | input | 1 | A peer cache supplies the requested line |
| peer_line | input | DW*WORDS | Line data from the peer |
| snp_valid | input | 1 | Another cache's request seen on the bus |
| snp_inv | input | 1 | Snooped kind: 1 = invalidate, 0 = read |
| snp_addr | input | AW-2 | Snooped line address |
| snp_supply | output | 1 | This cache supplies the snooped line |
| snp_line | output | DW*WORDS | Supplied line data |
| mem_rd | output | 1 | Memory line read pending |
| mem_rd_addr | output | AW-2 | Line address of the memory read |
| mem_cancel | output | 1 | Cancels the pending memory read |
| mem_ack | input | 1 | Memory returns the line |
| mem_line | input | DW*WORDS | Line data from memory |
| mem_wr | output | 1 | Line write-back to memory |
| mem_wr_addr | output | AW-2 | Line address of the write-back |
| mem_wr_line | output | DW*WORDS | Write-back data |

## Verification
The bench builds the block with its default parameters: a 12-bit word address, 16 lines of four 32-bit words, and 6-bit tags. With these values two word addresses that differ only in bits above bit 5 land on the same line. That makes eviction of a dirty victim, tag-mismatch snoops and same-index collisions reachable with a few accesses. The behavioural model tracks state, tag and data for every line. It predicts, for each access, how many cycles of bus read, bus invalidate, memory read and write-back should appear. The race cases are driven deliberately: an invalidate arriving while an upgrade waits, a snoop colliding with a store, and a peer and memory answering together.

// File: rtl/scm_pkg.sv
package scm_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } lstate_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_RESP,
        F_EVICT,
        F_BUSRD,
        F_WAITF,
        F_UPG
    } fsm_e;

endpackage

// File: rtl/scm_store.sv
module scm_store
    import scm_pkg::*;
#(
    parameter int LINES = 16,
    parameter int TW    = 6,
    parameter int LW    = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] a_idx,
    output lstate_e                  a_st,
    output logic [TW-1:0]            a_tag,
    output logic [LW-1:0]            a_line,
    input  logic [$clog2(LINES)-1:0] b_idx,
    output lstate_e                  b_st,
    output logic [TW-1:0]            b_tag,
    output logic [LW-1:0]            b_line,
    input  logic                     s_we,
    input  lstate_e                  s_st,
    input  logic                     f_we,
    input  lstate_e                  f_st,
    input  logic [TW-1:0]            f_tag,
    input  logic [LW-1:0]            f_line
);
    lstate_e       st_q   [LINES];
    logic [TW-1:0] tag_q  [LINES];
    logic [LW-1:0] line_q [LINES];

    // snoop update first, processor-side write last so it wins on a shared index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LS_I;
        end else begin
            if (s_we) st_q[b_idx] <= s_st;
            if (f_we) st_q[a_idx] <= f_st;
        end
    end

    always_ff @(posedge clk) begin
        if (f_we) begin
            tag_q[a_idx]  <= f_tag;
            line_q[a_idx] <= f_line;
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_line = line_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_line = line_q[b_idx];

endmodule

// File: rtl/scm_snoop.sv
module scm_snoop
    import scm_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          valid,
    input  logic          inv,
    input  logic [TW-1:0] tag,
    input  lstate_e       line_st,
    input  logic [TW-1:0] line_tag,
    output logic          supply,
    output logic          wb,
    output logic          st_we,
    output lstate_e       st_nx
);
    logic hit;

    assign hit    = valid && (line_st != LS_I) && (line_tag == tag);
    assign supply = hit && !inv;
    assign wb     = supply && (line_st == LS_M);
    assign st_we  = hit;
    assign st_nx  = inv ? LS_I : LS_S;

endmodule

// File: rtl/scm_ctrl.sv
module scm_ctrl
    import scm_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 32,
    parameter int LINES = 16,
    parameter int WORDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [AW-1:0]       cpu_addr,
    input  logic [DW-1:0]       cpu_wdata,
    output logic                cpu_done,
    output logic [DW-1:0]       cpu_rdata,
    output logic                bus_req,
    output logic                bus_inv,
    output logic [AW-3:0]       bus_addr,
    input  logic                bus_gnt,
    input  logic                peer_valid,
    input  logic [DW*WORDS-1:0] peer_line,
    input  logic                snp_valid,
    input  logic                snp_inv,
    input  logic [AW-3:0]       snp_addr,
    output logic                snp_supply,
    output logic [DW*WORDS-1:0] snp_line,
    output logic                mem_rd,
    output logic [AW-3:0]       mem_rd_addr,
    output logic                mem_cancel,
    input  logic                mem_ack,
    input  logic [DW*WORDS-1:0] mem_line,
    output logic                mem_wr,
    output logic [AW-3:0]       mem_wr_addr,
    output logic [DW*WORDS-1:0] mem_wr_line
);
    localparam int OW = $clog2(WORDS);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW - OW;
    localparam int LW = DW * WORDS;

    logic [OW-1:0] c_off;
    logic [IW-1:0] c_idx, s_idx;
    logic [TW-1:0] c_tag, s_tag;

    assign c_off = cpu_addr[OW-1:0];
    assign c_idx = cpu_addr[OW+IW-1:OW];
    assign c_tag = cpu_addr[AW-1:OW+IW];
    assign s_idx = snp_addr[IW-1:0];
    assign s_tag = snp_addr[AW-OW-1:IW];

    lstate_e       a_st, b_st, f_st, s_st;
    logic [TW-1:0] a_tag, b_tag;
    logic [LW-1:0] a_line, b_line, f_line, mod_line;
    logic          f_we, s_we, s_sup, s_wb;

    scm_store #(.LINES(LINES), .TW(TW), .LW(LW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (c_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_line (a_line),
        .b_idx  (s_idx),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_line (b_line),
        .s_we   (s_we),
        .s_st   (s_st),
        .f_we   (f_we),
        .f_st   (f_st),
        .f_tag  (c_tag),
        .f_line (f_line)
    );

    scm_snoop #(.TW(TW)) u_snoop (
        .valid    (snp_valid),
        .inv      (snp_inv),
        .tag      (s_tag),
        .line_st  (b_st),
        .line_tag (b_tag),
        .supply   (s_sup),
        .wb       (s_wb),
        .st_we    (s_we),
        .st_nx    (s_st)
    );

    logic a_hit, still_s, clash;
    assign a_hit   = (a_st != LS_I) && (a_tag == c_tag);
    assign still_s = a_hit && (a_st == LS_S);
    assign clash   = snp_valid && (s_idx == c_idx);

    always_comb begin
        mod_line = a_line;
        mod_line[c_off*DW +: DW] = cpu_wdata;
    end

    fsm_e          fsm_q, fsm_d;
    logic [DW-1:0] rdata_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= F_IDLE;
        else        fsm_q <= fsm_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (fsm_q == F_IDLE && fsm_d == F_RESP)
            rdata_q <= a_line[c_off*DW +: DW];
    end

    // transitions and array writes
    always_comb begin
        fsm_d  = fsm_q;
        f_we   = 1'b0;
        f_st   = a_st;
        f_line = a_line;
        unique case (fsm_q)
            F_IDLE: begin
                if (cpu_req && !clash) begin
                    if (a_hit) begin
                        if (!cpu_we) begin
                            fsm_d = F_RESP;
                        end else if (a_st == LS_S) begin
                            fsm_d = F_UPG;
                        end else begin
                            f_we   = 1'b1;
                            f_st   = LS_M;
                            f_line = mod_line;
                            fsm_d  = F_RESP;
                        end
                    end else if (a_st == LS_M) begin
                        fsm_d = F_EVICT;
                    end else begin
                        fsm_d = F_BUSRD;
                    end
                end
            end
            F_RESP:  fsm_d = F_IDLE;
            F_EVICT: if (!s_wb) fsm_d = F_BUSRD;
            F_BUSRD: if (bus_gnt) fsm_d = F_WAITF;
            F_WAITF: begin
                if (peer_valid) begin
                    f_we   = 1'b1;
                    f_st   = LS_S;
                    f_line = peer_line;
                    fsm_d  = F_IDLE;
                end else if (mem_ack) begin
                    f_we   = 1'b1;
                    f_st   = LS_E;
                    f_line = mem_line;
                    fsm_d  = F_IDLE;
                end
            end
            F_UPG: begin
                if (!still_s) begin
                    fsm_d = F_IDLE;
                end else if (bus_gnt) begin
                    f_we   = 1'b1;
                    f_st   = LS_M;
                    f_line = mod_line;
                    fsm_d  = F_RESP;
                end
            end
            default: fsm_d = F_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_done   = 1'b0;
        bus_req    = 1'b0;
        bus_inv    = 1'b0;
        mem_rd     = 1'b0;
        mem_cancel = 1'b0;
        mem_wr     = s_wb;
        unique case (fsm_q)
            F_IDLE:  ;
            F_RESP:  cpu_done = 1'b1;
            F_EVICT: if (!s_wb && a_st == LS_M) mem_wr = 1'b1;
            F_BUSRD: bus_req = 1'b1;
            F_WAITF: begin
                mem_rd     = 1'b1;
                mem_cancel = peer_valid;
            end
            F_UPG: begin
                bus_req = still_s;
                bus_inv = still_s;
            end
            default: ;
        endcase
    end

    assign cpu_rdata   = rdata_q;
    assign bus_addr    = {c_tag, c_idx};
    assign mem_rd_addr = {c_tag, c_idx};
    assign mem_wr_addr = s_wb ? {b_tag, s_idx} : {a_tag, c_idx};
    assign mem_wr_line = s_wb ? b_line : a_line;
    assign snp_supply  = s_sup;
    assign snp_line    = s_sup ? b_line : '0;

endmodule

// File: rtl/scm_chk.sv
module scm_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_done,
    input logic          bus_req,
    input logic          bus_inv,
    input logic [AW-3:0] bus_addr,
    input logic          bus_gnt,
    input logic          peer_valid,
    input logic          mem_rd,
    input logic          mem_ack,
    input logic          mem_cancel,
    input logic          snp_valid,
    input logic          snp_inv,
    input logic          snp_supply
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_inv && !bus_gnt |=> bus_req && !bus_inv && $stable(bus_addr));

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_ack && !peer_valid |=> mem_rd);

    // R5
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cancel |-> mem_rd && peer_valid);

    // R6
    inv_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_inv |-> bus_req);

    // R7
    supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_valid && !snp_inv);

endmodule

bind scm_ctrl scm_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_done   (cpu_done),
    .bus_req    (bus_req),
    .bus_inv    (bus_inv),
    .bus_addr   (bus_addr),
    .bus_gnt    (bus_gnt),
    .peer_valid (peer_valid),
    .mem_rd     (mem_rd),
    .mem_ack    (mem_ack),
    .mem_cancel (mem_cancel),
    .snp_valid  (snp_valid),
    .snp_inv    (snp_inv),
    .snp_supply (snp_supply)
);

// File: tb/sim_scm_ctrl.sv
module sim_scm_ctrl;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         cpu_req = 0, cpu_we = 0;
    logic [11:0]  cpu_addr = 0;
    logic [31:0]  cpu_wdata = 0;
    logic         cpu_done;
    logic [31:0]  cpu_rdata;
    logic         bus_req, bus_inv, bus_gnt = 0;
    logic [9:0]   bus_addr;
    logic         peer_valid = 0;
    logic [127:0] peer_line = 0;
    logic         snp_valid = 0, snp_inv = 0;
    logic [9:0]   snp_addr = 0;
    logic         snp_supply;
    logic [127:0] snp_line;
    logic         mem_rd, mem_cancel, mem_ack = 0, mem_wr;
    logic [9:0]   mem_rd_addr, mem_wr_addr;
    logic [127:0] mem_line = 0, mem_wr_line;

    always #5 clk = ~clk;

    scm_ctrl u0 (.*);

    int nchk = 0, nbad = 0;
    bit finished = 0;

    int           m_st  [16];
    int           m_tag [16];
    logic [127:0] m_line[16];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic snoop(input bit inv, input int addr, input string req);
        int  idx = (addr >> 2) & 15;
        int  tg  = (addr >> 6) & 63;
        bit  hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
        bit  sup = hit && !inv;
        bit  wb  = sup && (m_st[idx] == 3);
        snp_valid = 1; snp_inv = inv; snp_addr = 10'(addr >> 2);
        #1;
        chk(snp_supply == sup, req, "snp_supply", 128'(snp_supply), 128'(sup));
        if (sup) chk(snp_line == m_line[idx], req, "snp_line", snp_line, m_line[idx]);
        chk(mem_wr == wb, req, "snoop write-back", 128'(mem_wr), 128'(wb));
        if (wb) chk(mem_wr_line == m_line[idx] && mem_wr_addr == 10'(addr >> 2), req,
                    "snoop write-back data", mem_wr_line, m_line[idx]);
        @(posedge clk); #1;
        snp_valid = 0;
        #1;
        if (hit) m_st[idx] = inv ? 0 : 1;
    endtask

    task automatic acc(input bit we, input int addr, input logic [31:0] wd,
                       input bit peer, input bit both, input bit race, input bit clash,
                       input logic [127:0] fl, input string req);
        int  idx = (addr >> 2) & 15;
        int  tg  = (addr >> 6) & 63;
        int  off = addr & 3;
        int  n_rd = 0, n_inv = 0, n_wb = 0, n_mr = 0, cyc = 0, done_cyc = 0;
        int  e_rd, e_inv, e_wb, e_mr;
        bit  done = 0, raced = 0, waited = 0, hit0, vic_m;
        logic [9:0]   vic_addr;
        logic [127:0] vic_line;
        logic [31:0]  exp_rd;
        cpu_req = 1; cpu_we = we; cpu_addr = 12'(addr); cpu_wdata = wd;
        if (clash) begin
            bit h = (m_st[idx] != 0) && (m_tag[idx] == tg);
            snp_valid = 1; snp_inv = 0; snp_addr = 10'(addr >> 2);
            #1;
            chk(snp_supply == h, "R11", "snoop beside request", 128'(snp_supply), 128'(h));
            if (h) m_st[idx] = 1;
        end
        hit0     = (m_st[idx] != 0) && (m_tag[idx] == tg);
        vic_m    = !hit0 && (m_st[idx] == 3);
        vic_addr = 10'(m_tag[idx] * 16 + idx);
        vic_line = m_line[idx];
        e_rd  = (!hit0 || race) ? 2 : 0;
        e_mr  = (!hit0 || race) ? 1 : 0;
        e_wb  = vic_m ? 1 : 0;
        e_inv = race ? 1 : ((we && ((hit0 && m_st[idx] == 1) || (!hit0 && peer))) ? 2 : 0);
        while (!done && cyc < 60) begin
            @(posedge clk); #1;
            snp_valid = 0; bus_gnt = 0; peer_valid = 0; mem_ack = 0;
            cyc++;
            #1;
            if (mem_wr) begin
                n_wb++;
                chk(mem_wr_addr == vic_addr, "R10", "victim address", 128'(mem_wr_addr), 128'(vic_addr));
                chk(mem_wr_line == vic_line, "R10", "victim data", mem_wr_line, vic_line);
            end
            if (bus_req) begin
                if (bus_inv) n_inv++; else n_rd++;
                chk(bus_addr == 10'(addr >> 2), "R3", "bus address", 128'(bus_addr), 128'(addr >> 2));
                if (race && bus_inv && !raced) begin
                    raced = 1;
                    snp_valid = 1; snp_inv = 1; snp_addr = 10'(addr >> 2);
                    m_st[idx] = 0;
                end else if (waited) begin
                    bus_gnt = 1; waited = 0;
                end else begin
                    waited = 1;
                end
            end
            if (mem_rd) begin
                n_mr++;
                chk(mem_rd_addr == 10'(addr >> 2), "R3", "memory address", 128'(mem_rd_addr), 128'(addr >> 2));
                if (peer) begin peer_valid = 1; peer_line = fl; end
                if (!peer || both) begin mem_ack = 1; mem_line = both ? ~fl : fl; end
                #1;
                chk(mem_cancel == peer, "R5", "mem_cancel", 128'(mem_cancel), 128'(peer));
            end
            if (cpu_done) begin done = 1; done_cyc = cyc; end
        end
        chk(done, req, "completion", 128'(done), 128'(1));
        if (!hit0 || race) begin
            m_tag[idx] = tg; m_line[idx] = fl; m_st[idx] = peer ? 1 : 2;
        end
        exp_rd = m_line[idx][off*32 +: 32];
        if (we) begin
            m_line[idx][off*32 +: 32] = wd;
            m_st[idx] = 3;
        end else begin
            chk(cpu_rdata == exp_rd, req, "read data", 128'(cpu_rdata), 128'(exp_rd));
        end
        if (hit0 && !we && !clash)
            chk(done_cyc == 1, "R2", "hit latency", 128'(done_cyc), 128'(1));
        chk(n_rd == e_rd, (race ? "R6" : "R3"), "bus read cycles", 128'(n_rd), 128'(e_rd));
        chk(n_inv == e_inv, (race || clash ? "R6" : "R4"), "bus invalidate cycles", 128'(n_inv), 128'(e_inv));
        chk(n_wb == e_wb, "R10", "write-back count", 128'(n_wb), 128'(e_wb));
        chk(n_mr == e_mr, "R3", "memory read cycles", 128'(n_mr), 128'(e_mr));
        cpu_req = 0;
        @(posedge clk); #2;
        chk(cpu_done == 0, "R2", "done pulse length", 128'(cpu_done), 128'(0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nbad++; nchk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_st[i] = 0; m_tag[i] = 0; m_line[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #2;
        // R1
        chk(!cpu_done && !bus_req && !mem_rd && !mem_wr, "R1", "idle outputs",
            {cpu_done, bus_req, mem_rd, mem_wr}, 0);
        snoop(0, 12'h040, "R1");
        // R3 R4: read miss from memory, then hit, then silent store
        acc(0, 12'h104, 0, 0, 0, 0, 0, 128'h44444444_33333333_22222222_11111111, "R4");
        acc(0, 12'h105, 0, 0, 0, 0, 0, 0, "R2");
        acc(1, 12'h106, 32'hCAFE0001, 0, 0, 0, 0, 0, "R4");
        // R7: snooped read of a modified line
        snoop(0, 12'h104, "R7");
        acc(1, 12'h104, 32'hBEEF0002, 0, 0, 0, 0, 0, "R6");
        // R8: invalidate then miss served by a peer
        snoop(1, 12'h104, "R8");
        acc(0, 12'h107, 0, 1, 0, 0, 0, 128'h0d0d0d0d_0c0c0c0c_0b0b0b0b_0a0a0a0a, "R8");
        // R5: peer and memory answer together
        acc(0, 12'h208, 0, 1, 1, 0, 0, 128'h5555aaaa_6666bbbb_7777cccc_8888dddd, "R5");
        // R6: invalidated while waiting for the upgrade grant
        acc(1, 12'h20A, 32'h600D0003, 0, 0, 1, 0, 128'h12345678_9abcdef0_0fedcba9_87654321, "R6");
        // R10: dirty victim evicted
        acc(0, 12'h308, 0, 0, 0, 0, 0, 128'hf0f0f0f0_e1e1e1e1_d2d2d2d2_c3c3c3c3, "R10");
        // R9: tag-mismatch snoops leave the line alone
        snoop(0, 12'h208, "R9");
        snoop(1, 12'h208, "R9");
        acc(0, 12'h30B, 0, 0, 0, 0, 0, 0, "R9");
        // R11: snoop collides with a store to an exclusive line
        acc(1, 12'h309, 32'h77770004, 0, 0, 0, 1, 0, "R11");
        // write misses: peer fill needs upgrade, memory fill is silent
        acc(1, 12'h410, 32'h11110005, 1, 0, 0, 0, 128'h1, "R6");
        acc(1, 12'h514, 32'h22220006, 0, 0, 0, 0, 128'h2, "R4");
        acc(0, 12'h514, 0, 0, 0, 0, 0, 0, "R2");
        finished = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule